// File: doc/BRIEF.md
# Single-Bit-Shift Arithmetic Logic Unit

This block is the arithmetic and logic core of a 16-bit processor datapath. It is purely combinational. A result is produced from two operands, a 3-bit operation code and a 4-bit shift-kind field. The same unit serves several kinds of work:

- register-to-register arithmetic and logic;
- immediate forms, where the caller has already sign- or zero-extended the constant into operand B;
- effective address computation, which is an addition;
- branch comparison, which subtracts operand B from operand A and looks at the zero flag.

The shift class has no shift-amount field. Each shift operation moves operand A by exactly one bit position. The kind of shift is picked by the 4-bit shift-kind field, which leaves room for 16 kinds. Five kinds are defined; the other codes pass operand A through unchanged.

Internally, a decoder turns the operation code and shift kind into a small set of strobes. A datapath computes the arithmetic, logic, compare and shift values and selects one of them under those strobes.

Top module: `alu16_shift`

## Requirements
- R1: With `opSel` = 0, `result` is `opA + opB` modulo 2^16, with no overflow indication.
- R2: With `opSel` = 1, `result` is `opA - opB` modulo 2^16; equal operands give a result of 0.
- R3: With `opSel` = 2, `result` is the bitwise AND of the operands; with `opSel` = 3 it is the bitwise OR.
- R4: With `opSel` = 4, `result` is 1 when `opA` is less than `opB` as signed two's-complement numbers, and 0 otherwise. Bits 15..1 of the result are always 0.
- R5: With `opSel` = 5, shift kind 0 moves `opA` left by one bit and fills bit 0 with 0. Kind 1 moves it right by one bit and fills bit 15 with 0. Kind 2 moves it right by one bit and copies the old bit 15 into bit 15.
- R6: With `opSel` = 5, shift kind 3 rotates `opA` left by one bit, so old bit 15 lands in bit 0. Kind 4 rotates it right by one bit, so old bit 0 lands in bit 15.
- R7: With `opSel` = 5 and a shift kind from 5 to 15, `result` equals `opA`.
- R8: In the shift class (`opSel` = 5), the value of `opB` has no effect on `result`.
- R9: `zero` is 1 exactly when all 16 bits of `result` are 0, for every operation.
- R10: With `opSel` = 6 or 7, `result` is 0 and `zero` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand; also the value moved by the shift class |
| opB | input | 16 | Second operand, already extended by the caller when it is an immediate |
| opSel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed less-than, 5 shift class |
| shiftType | input | 4 | Shift kind, used only when `opSel` = 5 |
| result | output | 16 | Selected result |
| zero | output | 1 | High when `result` is all zeros |

## Verification
The unit holds no state, so every result and the zero flag are due in the same clock period in which the operands and codes are applied; no result lags by a cycle. The bench changes inputs on the falling edge of its clock and samples outputs one nanosecond later, so the combinational paths have settled well before the next rising edge. This also keeps every sample clear of the edge at which the next stimulus could be applied. The bench never waits a cycle for a result.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int DATA_W = 16;
  localparam int OP_W = 3;
  localparam int KIND_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SLT = 3'd4,
    OP_SHF = 3'd5
  } aluOp_e;

  typedef enum logic [KIND_W-1:0] {
    SK_LSL = 4'd0,
    SK_LSR = 4'd1,
    SK_ASR = 4'd2,
    SK_ROL = 4'd3,
    SK_ROR = 4'd4
  } shiftKind_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_ROT  = 2'd2
  } fillSrc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     arithEn;   // drive adder output onto result
    logic     invertB;   // subtract: invert B and carry in 1
    logic     andEn;
    logic     orEn;
    logic     sltEn;     // drive compare bit onto result
    logic     shiftEn;   // drive shifter output onto result
    logic     shLeft;
    logic     shPass;    // undefined kind: shifter passes A
    fillSrc_e shFill;
  } aluCtrl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int KW  = KIND_W
) (
  input  logic [OPW-1:0] opSel,
  input  logic [KW-1:0]  shiftType,
  output aluCtrl_t       ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.shFill = FILL_ZERO;
    case (opSel)
      OP_ADD: ctrl.arithEn = 1'b1;
      OP_SUB: begin
        ctrl.arithEn = 1'b1;
        ctrl.invertB = 1'b1;
      end
      OP_AND: ctrl.andEn = 1'b1;
      OP_OR:  ctrl.orEn  = 1'b1;
      OP_SLT: begin
        ctrl.sltEn   = 1'b1;
        ctrl.invertB = 1'b1;
      end
      OP_SHF: begin
        ctrl.shiftEn = 1'b1;
        case (shiftType)
          SK_LSL: ctrl.shLeft = 1'b1;
          SK_LSR: ctrl.shFill = FILL_ZERO;
          SK_ASR: ctrl.shFill = FILL_SIGN;
          SK_ROL: begin
            ctrl.shLeft = 1'b1;
            ctrl.shFill = FILL_ROT;
          end
          SK_ROR: ctrl.shFill = FILL_ROT;
          default: ctrl.shPass = 1'b1;
        endcase
      end
      default: ctrl = '0;
    endcase
  end

  // at most one result source is selected
  always_comb begin
    assert_one_source_R10: assert ($onehot0({ctrl.arithEn, ctrl.andEn, ctrl.orEn,
                                             ctrl.sltEn, ctrl.shiftEn}))
      else $error("more than one result source selected");
  end

endmodule

// File: rtl/alu16_dp.sv
module alu16_dp
  import alu16_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluCtrl_t     ctrl,
  output logic [W-1:0] result
);

  localparam int MSB = W - 1;

  logic [W-1:0] bIn;
  logic [W-1:0] sum;
  logic [W-1:0] andVal;
  logic [W-1:0] orVal;
  logic         lessThan;
  logic         fillLeft;
  logic         fillRight;
  logic [W-1:0] shVal;

  // adder: B inverted plus carry-in gives A - B
  assign bIn = ctrl.invertB ? ~opB : opB;
  assign sum = opA + bIn + {{(W-1){1'b0}}, ctrl.invertB};

  // per-bit logic unit
  for (genvar i = 0; i < W; i++) begin : g_logic
    assign andVal[i] = opA[i] & opB[i];
    assign orVal[i]  = opA[i] | opB[i];
  end

  // signed compare: differing signs decide directly, otherwise the
  // sign of the difference (no overflow possible then)
  assign lessThan = (opA[MSB] ^ opB[MSB]) ? opA[MSB] : sum[MSB];

  // one-bit shifter
  always_comb begin
    unique case (ctrl.shFill)
      FILL_SIGN: fillRight = opA[MSB];
      FILL_ROT:  fillRight = opA[0];
      default:   fillRight = 1'b0;
    endcase
    fillLeft = (ctrl.shFill == FILL_ROT) ? opA[MSB] : 1'b0;
    if (ctrl.shPass)
      shVal = opA;
    else if (ctrl.shLeft)
      shVal = {opA[MSB-1:0], fillLeft};
    else
      shVal = {fillRight, opA[MSB:1]};
  end

  // AND-OR result selection
  always_comb begin
    result = ({W{ctrl.arithEn}} & sum)
           | ({W{ctrl.andEn}}   & andVal)
           | ({W{ctrl.orEn}}    & orVal)
           | ({W{ctrl.shiftEn}} & shVal)
           | ({W{ctrl.sltEn}}   & {{(W-1){1'b0}}, lessThan});
  end

  // arithmetic right shift keeps the sign bit
  always_comb begin
    if (ctrl.shiftEn && !ctrl.shPass && !ctrl.shLeft && ctrl.shFill == FILL_SIGN) begin
      assert_asr_sign_R5: assert (result[MSB] == opA[MSB])
        else $error("arithmetic shift lost the sign bit");
    end
  end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int OPW = OP_W,
  parameter int KW  = KIND_W
) (
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [OPW-1:0] opSel,
  input  logic [KW-1:0]  shiftType,
  output logic [W-1:0]   result,
  output logic           zero
);

  aluCtrl_t ctrl;

  alu16_ctrl #(.OPW(OPW), .KW(KW)) u_ctrl (
    .opSel(opSel),
    .shiftType(shiftType),
    .ctrl(ctrl)
  );

  alu16_dp #(.W(W)) u_dp (
    .opA(opA),
    .opB(opB),
    .ctrl(ctrl),
    .result(result)
  );

  assign zero = ~|result;

  always_comb begin
    if (opSel == OP_SLT) begin
      assert_slt_narrow_R4: assert (result[W-1:1] == '0)
        else $error("compare result wider than one bit");
    end
    if (opSel == OP_SUB && opA == opB) begin
      assert_equal_sub_zero_R2: assert (zero)
        else $error("equal operands did not give zero");
    end
    if (opSel == OP_SHF && (shiftType == SK_ROL || shiftType == SK_ROR)) begin
      assert_rotate_keeps_ones_R6: assert ($countones(result) == $countones(opA))
        else $error("rotate changed the number of ones");
    end
    if (opSel == OP_SHF && shiftType == SK_LSL) begin
      assert_lsl_fill_R5: assert (result[0] == 1'b0)
        else $error("left shift filled a one");
    end
    if (opSel == OP_SHF && shiftType > SK_ROR) begin
      assert_pass_through_R7: assert (result == opA)
        else $error("undefined shift kind altered the operand");
    end
    if (opSel > OP_SHF) begin
      assert_undef_op_R10: assert (zero)
        else $error("undefined operation gave a nonzero result");
    end
  end

endmodule

// File: tb/sim_alu16_shift.sv
module sim_alu16_shift;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [3:0]  shiftType = '0;
  logic [15:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  alu16_shift u0 (
    .opA(opA), .opB(opB), .opSel(opSel), .shiftType(shiftType),
    .result(result), .zero(zero)
  );

  // {op, kind, A, B, expected}
  localparam int NV = 25;
  localparam logic [55:0] VEC [NV] = '{
    56'h0_0_1234_0FF0_2224,
    56'h0_0_FFFF_0001_0000,
    56'h0_0_0005_FFF8_FFFD,
    56'h1_0_0010_0001_000F,
    56'h1_0_0000_0001_FFFF,
    56'h1_0_5A5A_5A5A_0000,
    56'h2_0_F0F0_3C3C_3030,
    56'h3_0_F0F0_0F01_FFF1,
    56'h4_0_FFFF_0001_0001,
    56'h4_0_0001_FFFF_0000,
    56'h4_0_8000_7FFF_0001,
    56'h4_0_7FFF_8000_0000,
    56'h4_0_1234_1234_0000,
    56'h5_0_8001_0000_0002,
    56'h5_1_8001_0000_4000,
    56'h5_2_8002_0000_C001,
    56'h5_2_4002_0000_2001,
    56'h5_3_8001_0000_0003,
    56'h5_4_8001_0000_C000,
    56'h5_9_ABCD_0000_ABCD,
    56'h5_F_1357_0000_1357,
    56'h5_5_0000_FFFF_0000,
    56'h5_0_0001_FFFF_0002,
    56'h6_0_FFFF_FFFF_0000,
    56'h7_0_1234_4321_0000
  };

  function automatic string tagOf(input logic [3:0] op, input logic [3:0] kind);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return (kind <= 4'd2) ? "R5" : (kind <= 4'd4) ? "R6" : "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [3:0] kind,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opSel = op; shiftType = kind; opA = a; opB = b;
    #1;
  endtask

  task automatic checkOut(input string tag, input logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, exp);
    end
    checks++;
    if (zero !== (exp == 16'h0)) begin
      errors++;
      $display("FAIL R9 (%s) zero actual=%b expected=%b", tag, zero, exp == 16'h0);
    end
  endtask

  initial begin
    logic [15:0] first;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // idle state: all-zero inputs give an add of zeros
    apply(3'd0, 4'd0, 16'h0, 16'h0);
    checkOut("R1", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][54:52], VEC[i][51:48], VEC[i][47:32], VEC[i][31:16]);
      checkOut(tagOf(VEC[i][55:52], VEC[i][51:48]), VEC[i][15:0]);
    end

    // R8: sweep B under each defined shift kind, result must not move
    for (int k = 0; k < 5; k++) begin
      apply(3'd5, 4'(k), 16'hB6D3, 16'h0000);
      first = result;
      for (int b = 0; b < 4; b++) begin
        apply(3'd5, 4'(k), 16'hB6D3, 16'(16'h1111 * b + 16'h8421));
        checks++;
        if (result !== first) begin
          errors++;
          $display("FAIL R8 kind=%0d actual=%h expected=%h", k, result, first);
        end
      end
    end

    // R4: signed extremes
    apply(3'd4, 4'd0, 16'h8000, 16'h8001);
    checkOut("R4", 16'h0001);
    apply(3'd4, 4'd0, 16'h8001, 16'h8000);
    checkOut("R4", 16'h0000);

    // R2: branch-style compare of unequal operands gives nonzero
    apply(3'd1, 4'd0, 16'h0100, 16'h0101);
    checkOut("R2", 16'hFFFF);

    // R6: rotate of all ones stays all ones
    apply(3'd5, 4'd4, 16'hFFFF, 16'h0000);
    checkOut("R6", 16'hFFFF);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(40000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule